// File: doc/BRIEF.md
# Memory Protection Region Checker

This block guards a memory map with a small set of programmable protection regions. Software selects a region by writing a region-number register, then fills in that region's base address and a packed attribute word. The attribute word carries the enable bit, a power-of-two size code, an eight-bit mask that switches off subregions, the access-permission code, the execute-never flag and the memory-type bits. The memory-type bits are only stored and passed out. Only privileged writes reach the configuration registers.

A checker port takes one access per cycle: an address, a privilege flag, a write flag and an instruction-fetch flag. One clock later the block reports whether any region matched, which region won, and whether the access breaks that region's permissions. When regions overlap, the highest-numbered matching region decides. An access that matches no region is reported as a miss and is not faulted.

Top module: `mpu_region_check`

## Requirements
- R1: After reset every stored word reads zero, every region is disabled, `res_valid` is low, and an access to any address reports no hit and no fault.
- R2: Reading back the attribute word (window code 2) returns zero in bits 31:29, 27, 23:22 and 7:6, whatever was written. The writable layout is: XN at bit 28, AP at 26:24, TEX at 21:19, S/C/B at 18/17/16, subregion-disable mask at 15:8, size code at 5:1 and enable at bit 0.
- R3: An attribute write with `cfg_hw`=01 changes only bits 15:0, and one with `cfg_hw`=10 changes only bits 31:16. `cfg_hw`=11 writes the whole word.
- R4: A configuration write with `cfg_priv` low changes no register.
- R5: An enabled region with size code S (4 to 30) covers 2^(S+1) bytes starting at its base address; addresses outside that span miss. A region whose enable bit is clear never matches.
- R6: A size code below 4 makes the region invalid, so it never matches even when enabled.
- R7: Size code 31 covers the whole address map and ignores the base address.
- R8: A region is split into eight equal subregions, with the lowest addresses in subregion 0. An address in subregion k does not match when bit k of the disable mask is set.
- R9: When several regions match, the result reports the highest-numbered one.
- R10: Permission codes give these rights: 0 none; 1 privileged read/write only; 2 privileged read/write and unprivileged read; 3 full access; 5 privileged read only; 6 and 7 read only for everyone; 4 none. A matched access outside these rights raises `res_fault`.
- R11: An instruction fetch from a matched region with XN set raises `res_fault`, whatever the permission code.
- R12: A miss never faults and reports `res_attr` as zero. A hit reports the winning region's {TEX,S,C,B} bits on `res_attr`.
- R13: Results are registered: an access presented at one clock edge is reported after that edge with `res_valid` high. `res_valid` is low after any edge where `chk_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write window: 0 region number, 1 base address, 2 attribute word |
| cfg_hw | input | 2 | Halfword enables for attribute writes (bit 0 low half, bit 1 high half) |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 2 | Read window, same coding as `cfg_sel`, for the selected region |
| cfg_rdata | output | 32 | Registered read data |
| chk_valid | input | 1 | Access present |
| chk_addr | input | AW | Access address |
| chk_priv | input | 1 | Access is privileged |
| chk_write | input | 1 | Access is a write |
| chk_fetch | input | 1 | Access is an instruction fetch |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Some region matched |
| res_region | output | RW | Winning region number |
| res_fault | output | 1 | Permission fault |
| res_attr | output | 6 | Winning region's {TEX,S,C,B} |

## Verification
An access driven before edge k is reported just after edge k, so the bench drives on the falling edge and samples one time unit after the next rising edge. Register reads also take one edge. The bench finishes every write one full cycle before it reads or checks an access, so each result reflects the configuration that was intended. The bench also confirms that `res_valid` falls one edge after `chk_valid` is removed.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int SZ_MIN  = 4;
  localparam int SZ_FULL = 31;
  localparam int LOWB    = 5;

  localparam logic [1:0] SEL_NUM  = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_ATTR = 2'd2;

  // writable bits of the attribute word
  localparam logic [31:0] ATTR_WMASK = 32'h173F_FF3F;

  // field positions inside the attribute word
  localparam int F_EN   = 0;
  localparam int F_SZLO = 1;
  localparam int F_SRLO = 8;
  localparam int F_MTLO = 16;
  localparam int F_APLO = 24;
  localparam int F_XN   = 28;

  function automatic logic ap_allows(input logic [2:0] ap, input logic priv,
                                     input logic wr);
    logic ok;
    case (ap)
      3'd1:    ok = priv;
      3'd2:    ok = priv | ~wr;
      3'd3:    ok = 1'b1;
      3'd5:    ok = priv & ~wr;
      3'd6,
      3'd7:    ok = ~wr;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [1:0]      cfg_hw,
  input  logic            cfg_priv,
  input  logic [31:0]     cfg_wdata,
  input  logic [1:0]      cfg_rsel,
  output logic [31:0]     cfg_rdata,
  output logic [N*AW-1:0] base_flat,
  output logic [N*32-1:0] attr_flat
);
  logic [RW-1:0] cur_q;
  logic [AW-1:0] base_q [N];
  logic [31:0]   attr_q [N];
  logic          wr_ok;

  assign wr_ok = cfg_we & cfg_priv;

  always_ff @(posedge clk) begin
    if (rst) cur_q <= '0;
    else if (wr_ok && cfg_sel == SEL_NUM) cur_q <= cfg_wdata[RW-1:0];
  end

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i] <= '0;
        attr_q[i] <= '0;
      end else if (wr_ok && cur_q == RW'(i)) begin
        if (cfg_sel == SEL_BASE)
          base_q[i] <= {cfg_wdata[AW-1:LOWB], {LOWB{1'b0}}};
        if (cfg_sel == SEL_ATTR) begin
          if (cfg_hw[0]) attr_q[i][15:0]  <= cfg_wdata[15:0]  & ATTR_WMASK[15:0];
          if (cfg_hw[1]) attr_q[i][31:16] <= cfg_wdata[31:16] & ATTR_WMASK[31:16];
        end
      end
    end
    assign base_flat[i*AW +: AW] = base_q[i];
    assign attr_flat[i*32 +: 32] = attr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (cfg_rsel)
        SEL_NUM:  cfg_rdata <= 32'(cur_q);
        SEL_BASE: cfg_rdata <= 32'(base_q[cur_q]);
        SEL_ATTR: cfg_rdata <= attr_q[cur_q];
        default:  cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic          en,
  input  logic [4:0]    size,
  input  logic [7:0]    srd,
  output logic          match
);
  logic [AW:0] diff;
  logic [5:0]  sh_hi;
  logic [4:0]  sh_lo;
  logic [2:0]  sub;
  logic        in_span;

  always_comb begin
    sh_hi   = {1'b0, size} + 6'd1;
    sh_lo   = size - 5'd2;
    diff    = {1'b0, addr ^ base} >> sh_hi;
    sub     = 3'(addr >> sh_lo);
    in_span = (size == 5'(SZ_FULL)) || (diff == '0);
    match   = en && (size >= 5'(SZ_MIN)) && in_span && !srd[sub];
  end
endmodule

// File: rtl/mpu_priority_sel.sv
module mpu_priority_sel #(
  parameter int N = 4,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  match,
  output logic          hit,
  output logic [RW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = RW'(i);
      end
    end
  end
endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int AW = 32,
  localparam int RW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [1:0]    cfg_hw,
  input  logic          cfg_priv,
  input  logic [31:0]   cfg_wdata,
  input  logic [1:0]    cfg_rsel,
  output logic [31:0]   cfg_rdata,
  input  logic          chk_valid,
  input  logic [AW-1:0] chk_addr,
  input  logic          chk_priv,
  input  logic          chk_write,
  input  logic          chk_fetch,
  output logic          res_valid,
  output logic          res_hit,
  output logic [RW-1:0] res_region,
  output logic          res_fault,
  output logic [5:0]    res_attr
);
  logic [NUM_REGIONS*AW-1:0] base_flat;
  logic [NUM_REGIONS*32-1:0] attr_flat;
  logic [NUM_REGIONS-1:0]    match;
  logic                      any_hit;
  logic [RW-1:0]             win;
  logic [31:0]               win_attr;
  logic                      allow;
  logic                      fault_c;

  mpu_cfg_regs #(.N(NUM_REGIONS), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_hw(cfg_hw),
    .cfg_priv(cfg_priv), .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel),
    .cfg_rdata(cfg_rdata), .base_flat(base_flat), .attr_flat(attr_flat)
  );

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_match
    mpu_region_match #(.AW(AW)) u_m (
      .addr (chk_addr),
      .base (base_flat[i*AW +: AW]),
      .en   (attr_flat[i*32 + F_EN]),
      .size (attr_flat[i*32 + F_SZLO +: 5]),
      .srd  (attr_flat[i*32 + F_SRLO +: 8]),
      .match(match[i])
    );
  end

  mpu_priority_sel #(.N(NUM_REGIONS)) u_pri (
    .match(match), .hit(any_hit), .idx(win)
  );

  always_comb begin
    win_attr = attr_flat[32*win +: 32];
    allow    = ap_allows(win_attr[F_APLO +: 3], chk_priv, chk_write);
    fault_c  = any_hit && (!allow || (chk_fetch && win_attr[F_XN]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_region <= '0;
      res_fault  <= 1'b0;
      res_attr   <= '0;
    end else begin
      res_valid  <= chk_valid;
      res_hit    <= chk_valid && any_hit;
      res_region <= (chk_valid && any_hit) ? win : '0;
      res_fault  <= chk_valid && fault_c;
      res_attr   <= (chk_valid && any_hit) ? win_attr[F_MTLO +: 6] : '0;
    end
  end
endmodule

// File: rtl/mpu_region_check_sva.sv
module mpu_region_check_sva #(
  parameter int N = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic          cfg_priv,
  input logic          chk_valid,
  input logic          res_valid,
  input logic          res_hit,
  input logic          res_fault,
  input logic [5:0]    res_attr,
  input logic [N*32-1:0] attr_flat
);
  // R1: first cycle after reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && !res_hit && !res_fault));

  // R4: unprivileged writes leave the attribute store untouched
  a_r4_unpriv_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_priv) |=> $stable(attr_flat));

  // R12: a miss is never faulted
  a_r12_miss_no_fault: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> !res_fault);

  // R12: a miss carries no attributes
  a_r12_miss_attr_zero: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_attr == 6'd0));

  // R13: a presented access is reported on the next edge
  a_r13_valid_follows: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> res_valid);

  // R13: no access, no result
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> (!res_valid && !res_hit));
endmodule

bind mpu_region_check mpu_region_check_sva #(.N(NUM_REGIONS)) u_sva (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
  .chk_valid(chk_valid), .res_valid(res_valid), .res_hit(res_hit),
  .res_fault(res_fault), .res_attr(res_attr), .attr_flat(attr_flat)
);

// File: tb/sim_mpu_region_check.sv
module sim_mpu_region_check;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [1:0]    cfg_hw = 2'b11;
  logic          cfg_priv = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [1:0]    cfg_rsel = 2'd2;
  logic [31:0]   cfg_rdata;
  logic          chk_valid = 1'b0;
  logic [AW-1:0] chk_addr = '0;
  logic          chk_priv = 1'b0;
  logic          chk_write = 1'b0;
  logic          chk_fetch = 1'b0;
  logic          res_valid, res_hit, res_fault;
  logic [RW-1:0] res_region;
  logic [5:0]    res_attr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  mpu_region_check #(.NUM_REGIONS(N), .AW(AW)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d,
                    input logic [1:0] hw = 2'b11, input logic priv = 1'b1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_hw = hw; cfg_priv = priv;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0; cfg_hw = 2'b11;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    cfg_rsel = sel;
    @(posedge clk); #1;
    d = cfg_rdata;
  endtask

  task automatic set_region(input int r, input logic [31:0] base, input logic [31:0] attr);
    wr(2'd0, 32'(r));
    wr(2'd1, base);
    wr(2'd2, attr);
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic p,
                        input logic w, input logic f, input logic eh,
                        input int er, input logic ef);
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = a; chk_priv = p; chk_write = w; chk_fetch = f;
    @(posedge clk); #1;
    chk({tag, " valid"}, 32'(res_valid), 32'd1);
    chk({tag, " hit"},   32'(res_hit),   32'(eh));
    if (eh) chk({tag, " region"}, 32'(res_region), 32'(er));
    chk({tag, " fault"}, 32'(res_fault), 32'(ef));
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  function automatic logic exp_allow(input int ap, input logic p, input logic w);
    if (ap == 3) return 1'b1;
    if (ap == 6 || ap == 7) return !w;
    if (ap == 2) return p || !w;
    if (ap == 1) return p;
    if (ap == 5) return p && !w;
    return 1'b0;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 res_valid", 32'(res_valid), 32'd0);
    rd(2'd2, d); chk("R1 attr", d, 32'd0);
    rd(2'd1, d); chk("R1 base", d, 32'd0);
    access("R1 any", 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    access("R1 top", 32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_write_rules();
    logic [31:0] d;
    wr(2'd0, 32'd0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R2 reserved", d, 32'h173F_FF3F);
    wr(2'd2, 32'h0000_0013, 2'b01);
    rd(2'd2, d); chk("R3 low half", d, 32'h173F_0013);
    wr(2'd2, 32'h0100_FFFF, 2'b10);
    rd(2'd2, d); chk("R3 high half", d, 32'h0100_0013);
    wr(2'd2, 32'h0000_0000, 2'b11, 1'b0);
    rd(2'd2, d); chk("R4 unpriv attr", d, 32'h0100_0013);
    wr(2'd1, 32'h0000_8000, 2'b11, 1'b0);
    rd(2'd1, d); chk("R4 unpriv base", d, 32'd0);
    wr(2'd2, 32'd0);
  endtask

  task automatic t_size();
    logic [31:0] d;
    set_region(0, 32'h0000_1000, 32'h0300_0013);
    rd(2'd1, d); chk("R5 base rd", d, 32'h0000_1000);
    access("R5 last", 32'h0000_13FC, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b0);
    access("R5 above", 32'h0000_1400, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    access("R5 below", 32'h0000_0FFC, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    wr(2'd2, 32'h0300_0012);
    access("R5 disabled", 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    set_region(0, 32'h0, 32'h0300_0007);
    access("R6 code3", 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    wr(2'd2, 32'h0300_0009);
    access("R6 code4 in", 32'h0000_001F, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b0);
    access("R6 code4 out", 32'h0000_0020, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    set_region(1, 32'h0000_1000, 32'h0300_003F);
    access("R7 full", 32'hF000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1, 1'b0);
    wr(2'd2, 32'd0);
  endtask

  task automatic t_subregion();
    set_region(0, 32'h0000_1000, 32'h0300_0413);
    access("R8 sub2 start", 32'h0000_1100, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    access("R8 sub2 end", 32'h0000_117F, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    access("R8 sub3", 32'h0000_1180, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b0);
    access("R8 sub0", 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b0);
  endtask

  task automatic t_priority();
    set_region(2, 32'h0, 32'h0300_003F);
    set_region(3, 32'h0000_1000, 32'h0300_0013);
    access("R9 overlap", 32'h0000_1004, 1'b1, 1'b0, 1'b0, 1'b1, 3, 1'b0);
    access("R9 backdrop", 32'h0000_8000, 1'b1, 1'b0, 1'b0, 1'b1, 2, 1'b0);
  endtask

  task automatic t_perm();
    for (int ap = 0; ap < 8; ap++) begin
      wr(2'd0, 32'd3);
      wr(2'd2, 32'h0000_0013 | (32'(ap) << 24));
      for (int k = 0; k < 4; k++) begin
        logic p, w;
        p = k[1]; w = k[0];
        access($sformatf("R10 ap%0d p%0d w%0d", ap, p, w), 32'h0000_1010,
               p, w, 1'b0, 1'b1, 3, !exp_allow(ap, p, w));
      end
    end
    wr(2'd2, 32'h1300_0013);
    access("R11 xn fetch", 32'h0000_1010, 1'b1, 1'b0, 1'b1, 1'b1, 3, 1'b1);
    access("R11 xn read", 32'h0000_1010, 1'b1, 1'b0, 1'b0, 1'b1, 3, 1'b0);
  endtask

  task automatic t_miss_attr();
    wr(2'd0, 32'd2);
    wr(2'd2, 32'd0);
    wr(2'd0, 32'd3);
    wr(2'd2, 32'h0000_0013);
    access("R12 miss", 32'h0000_8000, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    chk("R12 miss attr", 32'(res_attr), 32'd0);
    wr(2'd2, 32'h032D_0013);
    access("R12 hit", 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b1, 3, 1'b0);
    chk("R12 attr out", 32'(res_attr), 32'h2D);
    @(posedge clk); #1;
    chk("R13 idle", 32'(res_valid), 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_write_rules();
        t_size();
        t_subregion();
        t_priority();
        t_perm();
        t_miss_attr();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule